// File: doc/BRIEF.md
# Overlapping Two-Digit BCD Pattern Detector

This block watches a serial bit stream, one bit per clock when a valid qualifier is high. It raises a one-bit flag whenever the most recent valid bits spell a fixed target. The target is built at elaboration time from two decimal digits. Each digit becomes its 4-bit BCD code, and the two codes are joined into an 8-bit sequence.

The tens digit's code arrives first, and each code arrives most-significant bit first. For example, digits 8 and 5 give the stream order 1,0,0,0,0,1,0,1. Occurrences may share bits, so the tail of one hit can start the next.

Inside, a nine-state machine counts how many leading pattern bits are currently matched. When a bit breaks the run, the next state is looked up in a table. The table gives the longest pattern prefix that is still a suffix of what has been seen, and it is computed from the digit parameters during elaboration. The flag is driven in the same cycle as the bit that completes the pattern. A digit parameter outside 0 to 9 stops elaboration.

Top module: `seqdet_bcd`

## Requirements
- R1: The target is the tens digit's 4-bit BCD code followed by the units digit's code, each sent most-significant bit first. With DIGIT_HI=8 and DIGIT_LO=5 the stream 1,0,0,0,0,1,0,1 is a hit, and the digit-swapped order 0,1,0,1,1,0,0,0 is not.
- R2: `match` is high during the very cycle in which the completing bit is presented with `in_valid` high. It is combinational from `in_bit`/`in_valid` and the current state, and needs no extra clock.
- R3: Overlapping occurrences are all reported. For digits 5,5 (01010101), each further valid "01" pair after the first hit gives another hit. For digits 0,0, every valid 0 after eight zeros gives a hit.
- R4: While `in_valid` is low, `match` is 0 and the matched-bit count is held. A pattern split by idle cycles is still found on its completing valid bit.
- R5: A synchronous, active-high `rst` returns the detector to zero bits matched. Bits received before reset never count toward a hit, so no hit is possible until 8 valid bits have arrived after reset.
- R6: For any stream, `match` equals the comparison of the last 8 valid bits since reset against the target. There are no false hits and no missed hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Serial data bit |
| in_valid | input | 1 | High when `in_bit` carries a stream bit this cycle |
| match | output | 1 | High in the cycle the target sequence completes |

## Verification
The embedded properties assume that `in_bit` and `in_valid` are settled well before the rising edge. They also assume that `in_valid` is held low during reset, because `match` is not gated by `rst`. The shadow history inside the checks counts only bits accepted while reset is low.

The stimulus changes inputs only on the falling edge, keeps `in_valid` low whenever `rst` is high, and samples `match` mid-cycle after the inputs settle. Four digit pairs with different overlap structure share one stream: 8,5 / 5,5 / 0,0 / 9,9.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int unsigned BCD_W   = 4;
  localparam int unsigned MAX_PAT = 32;

  // Join two decimal digits into a BCD pattern; tens digit in the upper nibble
  // so that it is shifted out first when the pattern is read MSB first.
  function automatic logic [2*BCD_W-1:0] bcd_pair(input int unsigned hi,
                                                 input int unsigned lo);
    logic [BCD_W-1:0] h;
    logic [BCD_W-1:0] l;
    h = BCD_W'(hi);
    l = BCD_W'(lo);
    return {h, l};
  endfunction

  // Next matched-bit count after k bits matched and bit b arrives.
  // Stream position m of the pattern is pat[len-1-m].
  function automatic int unsigned next_count(input logic [MAX_PAT-1:0] pat,
                                             input int unsigned len,
                                             input int unsigned k,
                                             input logic b);
    int unsigned best;
    int unsigned m;
    logic        ok;
    logic        s;
    best = 0;
    for (int unsigned cand = 1; cand <= MAX_PAT; cand++) begin
      if (cand <= k + 1 && cand <= len) begin
        ok = 1'b1;
        for (int unsigned j = 0; j < MAX_PAT; j++) begin
          if (j < cand) begin
            m = k + 1 - cand + j;
            s = (m < k) ? pat[len-1-m] : b;
            if (s != pat[len-1-j]) ok = 1'b0;
          end
        end
        if (ok) best = cand;
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/seqdet_trans.sv
module seqdet_trans #(
  parameter int unsigned PAT_W   = 8,
  parameter int unsigned ST_W    = 4,
  parameter logic [PAT_W-1:0] PATTERN = '0
) (
  input  logic [ST_W-1:0] cur,
  input  logic            in_bit,
  output logic [ST_W-1:0] nxt,
  output logic            full
);
  localparam int unsigned N_ENT = 2 * (PAT_W + 1);
  localparam int unsigned IDX_W = ST_W + 1;

  logic [ST_W-1:0]  tbl [N_ENT];
  logic [IDX_W-1:0] idx;

  // One entry per (matched count, incoming bit), fixed at elaboration
  for (genvar k = 0; k <= PAT_W; k++) begin : g_state
    for (genvar b = 0; b < 2; b++) begin : g_bit
      localparam int unsigned NXT = seqdet_pkg::next_count(
          seqdet_pkg::MAX_PAT'(PATTERN), PAT_W, k, 1'(b));
      assign tbl[2*k+b] = ST_W'(NXT);
    end
  end

  assign idx = {cur, in_bit};

  always_comb begin
    nxt = '0;
    if (int'(idx) < N_ENT) nxt = tbl[idx];
  end

  assign full = (nxt == ST_W'(PAT_W));

endmodule

// File: rtl/seqdet_state.sv
module seqdet_state #(
  parameter int unsigned ST_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [ST_W-1:0] d,
  output logic [ST_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= d;
  end
endmodule

// File: rtl/seqdet_bcd.sv
module seqdet_bcd #(
  parameter int unsigned DIGIT_HI = 8,
  parameter int unsigned DIGIT_LO = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  output logic match
);
  localparam int unsigned PAT_W = 2 * seqdet_pkg::BCD_W;
  localparam int unsigned ST_W  = $clog2(PAT_W + 1);
  localparam logic [PAT_W-1:0] PATTERN = seqdet_pkg::bcd_pair(DIGIT_HI, DIGIT_LO);

  if (DIGIT_HI > 9) begin : g_bad_hi
    $error("seqdet_bcd: DIGIT_HI must be a decimal digit");
  end
  if (DIGIT_LO > 9) begin : g_bad_lo
    $error("seqdet_bcd: DIGIT_LO must be a decimal digit");
  end

  logic [ST_W-1:0] state;
  logic [ST_W-1:0] state_nxt;
  logic            hit;

  seqdet_trans #(.PAT_W(PAT_W), .ST_W(ST_W), .PATTERN(PATTERN)) u_trans (
    .cur(state), .in_bit(in_bit), .nxt(state_nxt), .full(hit)
  );

  seqdet_state #(.ST_W(ST_W)) u_state (
    .clk(clk), .rst(rst), .adv(in_valid), .d(state_nxt), .q(state)
  );

  // Flag aligned with the completing bit (Mealy)
  assign match = in_valid & hit;

  // Shadow history of accepted bits for the checks below
  logic [PAT_W-2:0] ast_hist;
  logic [ST_W-1:0]  ast_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      ast_hist <= '0;
      ast_seen <= '0;
    end else if (in_valid) begin
      ast_hist <= {ast_hist[PAT_W-3:0], in_bit};
      if (ast_seen < ST_W'(PAT_W)) ast_seen <= ast_seen + 1'b1;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state <= ST_W'(PAT_W)); // R6
  AST_NO_FALSE_HIT: assert property (@(posedge clk) disable iff (rst)
    match |-> ({ast_hist, in_bit} == PATTERN && ast_seen >= ST_W'(PAT_W - 1))); // R6
  AST_NO_MISSED_HIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ast_seen >= ST_W'(PAT_W - 1) && {ast_hist, in_bit} == PATTERN) |-> match); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state == '0)); // R5

endmodule

// File: tb/tb_seqdet_bcd.sv
module tb_seqdet_bcd;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] got;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [7:0] PATS [4] = '{8'h85, 8'h55, 8'h00, 8'h99};

  logic [6:0] hist;
  int seen;
  logic [31:0] rnd = 32'h1234_5678;

  always #10 clk = ~clk;

  seqdet_bcd #(.DIGIT_HI(8), .DIGIT_LO(5)) dut (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid), .match(got[0]));
  seqdet_bcd #(.DIGIT_HI(5), .DIGIT_LO(5)) dut_b (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid), .match(got[1]));
  seqdet_bcd #(.DIGIT_HI(0), .DIGIT_LO(0)) dut_c (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid), .match(got[2]));
  seqdet_bcd #(.DIGIT_HI(9), .DIGIT_LO(9)) dut_d (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid), .match(got[3]));

  task automatic check(input string req, input int idx, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s det%0d pattern=%b actual=%b expected=%b", req, idx, PATS[idx], act, exp);
    end
  endtask

  function automatic logic [31:0] next_rnd();
    rnd ^= rnd << 13;
    rnd ^= rnd >> 17;
    rnd ^= rnd << 5;
    return rnd;
  endfunction

  // One cycle: drive at falling edge, check mid-cycle, update reference
  task automatic step(input logic b, input logic v, input string req);
    @(negedge clk);
    in_bit = b;
    in_valid = v;
    #2;
    for (int i = 0; i < 4; i++)
      check(req, i, got[i], v && seen >= 7 && {hist, b} == PATS[i]);
    if (v) begin
      hist = {hist[5:0], b};
      if (seen < 7) seen++;
    end
  endtask

  task automatic send_word(input logic [7:0] w, input string req);
    for (int i = 7; i >= 0; i--) step(w[i], 1'b1, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      for (int j = 0; j < 4; j++) check("R5", j, got[j], 1'b0);
    end
    rst = 1'b0;
    hist = '0;
    seen = 0;
  endtask

  task automatic t_exact();
    t_reset();
    send_word(8'h85, "R1");
    send_word(8'h58, "R1");
    // Explicit timing point: flag on the eighth bit, not a cycle later
    send_word(8'h99, "R2");
    @(negedge clk); in_valid = 1'b0; #2;
    check("R2", 3, got[3], 1'b0);
  endtask

  task automatic t_overlap();
    t_reset();
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1, "R3");
      step(1'b1, 1'b1, "R3");
    end
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, "R3");
    // 8,5 with one shared bit: 1000010 1 0000101
    send_word(8'h85, "R3");
    for (int i = 6; i >= 0; i--) step(PATS[0][i], 1'b1, "R3");
  endtask

  task automatic t_gaps();
    t_reset();
    for (int i = 7; i >= 0; i--) begin
      step(1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, "R4");
      step(PATS[0][i], 1'b1, "R4");
    end
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R4");
  endtask

  task automatic t_reset_mid();
    t_reset();
    for (int i = 7; i >= 4; i--) step(PATS[0][i], 1'b1, "R5");
    t_reset();
    for (int i = 3; i >= 0; i--) step(PATS[0][i], 1'b1, "R5");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R5");
  endtask

  task automatic t_random();
    logic [31:0] r;
    t_reset();
    for (int n = 0; n < 1500; n++) begin
      r = next_rnd();
      if (r[7:0] < 8'd12) send_word(PATS[r[9:8]], "R6");
      else step(r[16], r[20:18] != 3'd0, "R6");
    end
  endtask

  initial begin
    hist = '0;
    seen = 0;
    t_exact();
    t_overlap();
    t_gaps();
    t_reset_mid();
    t_random();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule